// File: doc/BRIEF.md
# Adaptive Slip Control Queue

This block holds synchronisation tokens between a prefetching producer and a load-issuing consumer. It bounds how many loop iterations the producer may run ahead. When the producer has issued the prefetches for one iteration, it deposits a token. Before the consumer issues the loads of the same iteration, it must withdraw a token. The largest number of tokens the queue will hold is the slip size. The queue changes the slip size by itself while it runs.

Each prefetch that completes is reported as one classification. The classification says whether the data came back before the matching load issued (useful) or after it (late). The block keeps a tally of each kind. After every fixed number of classifications it reviews the window:
- If the prefetch buffer reports full at that moment, the slip size is held.
- Otherwise, if the late prefetches are weighted double and outnumber the useful ones, the slip size grows by one.
- In every other case it shrinks by one.

After the review the tallies restart from zero. When the slip size drops below the number of tokens already held, no tokens are lost. Deposits simply stall until the consumer has drained the queue below the new limit.

Top module: `adaptive_slip_queue`

## Requirements
- R1: While rst_n is low and right after it is released, token_count is 0, slip_size is INIT_SLIP (default 4), put_ready is 1 and get_ready is 0.
- R2: A deposit (put_valid high while put_ready is high, with no accepted withdrawal) raises token_count by one at the next clock edge.
- R3: put_ready is low whenever token_count is greater than or equal to slip_size. A deposit offered then is refused and leaves token_count unchanged.
- R4: get_ready is high exactly when token_count is nonzero. An accepted withdrawal lowers token_count by one. A withdrawal offered at zero has no effect.
- R5: An accepted deposit and an accepted withdrawal in the same cycle leave token_count unchanged.
- R6: Only cycles with pf_done_valid high count as classifications. The slip size can change only at the clock edge that ends the cycle carrying the EVAL_WIN-th classification of a window (default 32). Both tallies then restart from zero, so the next window is judged on its own samples.
- R7: At a review with pf_buf_full low, if twice the late count exceeds the useful count, slip_size grows by one. pf_done_late=1 marks a late prefetch and 0 a useful one. The counts include the classification of the reviewing cycle. Example: 11 late against 21 useful grows the size.
- R8: At a review with pf_buf_full low where twice the late count does not exceed the useful count, slip_size shrinks by one. Example: 10 late against 22 useful shrinks the size.
- R9: If pf_buf_full is high in the reviewing cycle, slip_size is held. pf_buf_full in any other cycle has no effect on the outcome.
- R10: slip_size stays within MIN_SLIP (1) and MAX_SLIP (default 16). A grow at MAX_SLIP or a shrink at MIN_SLIP leaves it unchanged, and no change is ever larger than one.
- R11: A shrink below the current token_count removes no tokens. Deposits stay refused until withdrawals bring token_count below the new slip_size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| put_valid | input | 1 | Producer offers one token |
| put_ready | output | 1 | Queue can accept a token this cycle |
| get_valid | input | 1 | Consumer requests one token |
| get_ready | output | 1 | A token is available this cycle |
| pf_done_valid | input | 1 | One prefetch classification is presented |
| pf_done_late | input | 1 | 1: prefetch was late, 0: prefetch was useful |
| pf_buf_full | input | 1 | Prefetch buffer full status |
| slip_size | output | $clog2(MAX_SLIP+1) | Current permitted slip distance |
| token_count | output | $clog2(MAX_SLIP+1) | Tokens currently held |

## Verification
The bound checker watches every cycle for the following:
- token_count moves by exactly the net of accepted deposits and withdrawals;
- slip_size stays in range and changes by at most one;
- slip_size stays still except at the close of a window, and also while the buffer is full.

The checker cannot know which way a review should go. Only the bench scenarios show that:
- the weighted late-versus-useful decision, including the tie-breaking split on either side of the threshold;
- the clamping at both ends;
- that tallies start afresh each window;
- that a shrink below the held count only blocks deposits.

// File: rtl/scq_pkg.sv
package scq_pkg;

  // Outcome of a window review, consumed by the depth controller
  typedef enum logic [1:0] {
    SZ_HOLD   = 2'b00,
    SZ_GROW   = 2'b01,
    SZ_SHRINK = 2'b10
  } size_act_e;

endpackage

// File: rtl/scq_token_ctr.sv
// Token occupancy counter with a movable upper limit.
module scq_token_ctr #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             put_req,
  input  logic             get_req,
  input  logic [CNT_W-1:0] limit,
  output logic             put_ok,
  output logic             get_ok,
  output logic [CNT_W-1:0] count
);

  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] count_d;
  logic             put_acc;
  logic             get_acc;
  logic             count_en;

  // magnitude compare: the limit may fall below the held count
  assign put_ok  = (count_q < limit);
  assign get_ok  = (count_q != '0);
  assign put_acc = put_req & put_ok;
  assign get_acc = get_req & get_ok;

  always_comb begin
    count_en = put_acc ^ get_acc;
    count_d  = count_q;
    if (put_acc && !get_acc) begin
      count_d = count_q + 1'b1;
    end else if (get_acc && !put_acc) begin
      count_d = count_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (count_en) begin
      count_q <= count_d;
    end
  end

  assign count = count_q;

endmodule

// File: rtl/scq_timeliness_mon.sv
// Tallies late and useful prefetches and issues a resize decision per window.
module scq_timeliness_mon
  import scq_pkg::*;
#(
  parameter int EVAL_WIN = 32
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cls_valid,
  input  logic      cls_late,
  input  logic      buf_full,
  output size_act_e act
);

  localparam int WIN_W   = (EVAL_WIN > 1) ? $clog2(EVAL_WIN) : 1;
  localparam int TALLY_W = $clog2(EVAL_WIN + 1);

  logic [WIN_W-1:0]   win_q, win_d;
  logic [TALLY_W-1:0] late_q, late_d;
  logic [TALLY_W-1:0] useful_q, useful_d;
  logic [TALLY_W-1:0] late_tot, useful_tot;
  logic               win_last;
  logic               grow_cond;

  // window end detection: all-ones for a power of two, compare otherwise
  generate
    if ((EVAL_WIN & (EVAL_WIN - 1)) == 0) begin : g_pow2_win
      assign win_last = &win_q;
    end else begin : g_cmp_win
      assign win_last = (win_q == WIN_W'(EVAL_WIN - 1));
    end
  endgenerate

  always_comb begin
    late_tot   = late_q   + {{(TALLY_W-1){1'b0}}, cls_late};
    useful_tot = useful_q + {{(TALLY_W-1){1'b0}}, ~cls_late};
    // twice late against useful, one extra bit of headroom on both sides
    grow_cond  = ({late_tot, 1'b0} > {1'b0, useful_tot});

    act = SZ_HOLD;
    if (cls_valid && win_last && !buf_full) begin
      act = grow_cond ? SZ_GROW : SZ_SHRINK;
    end
  end

  always_comb begin
    win_d    = win_q;
    late_d   = late_q;
    useful_d = useful_q;
    if (cls_valid) begin
      if (win_last) begin
        win_d    = '0;
        late_d   = '0;
        useful_d = '0;
      end else begin
        win_d    = win_q + 1'b1;
        late_d   = late_tot;
        useful_d = useful_tot;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q    <= '0;
      late_q   <= '0;
      useful_q <= '0;
    end else if (cls_valid) begin
      win_q    <= win_d;
      late_q   <= late_d;
      useful_q <= useful_d;
    end
  end

endmodule

// File: rtl/scq_depth_ctl.sv
// Holds the permitted slip distance and applies clamped single steps.
module scq_depth_ctl
  import scq_pkg::*;
#(
  parameter int SZ_W    = 5,
  parameter int MIN_SZ  = 1,
  parameter int MAX_SZ  = 16,
  parameter int INIT_SZ = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  size_act_e       act,
  output logic [SZ_W-1:0] size
);

  logic [SZ_W-1:0] size_q, size_d;
  logic            at_max, at_min;
  logic            size_en;

  assign at_max = (size_q >= SZ_W'(MAX_SZ));
  assign at_min = (size_q <= SZ_W'(MIN_SZ));

  always_comb begin
    size_d  = size_q;
    size_en = 1'b0;
    unique case (act)
      SZ_GROW: begin
        if (!at_max) begin
          size_d  = size_q + 1'b1;
          size_en = 1'b1;
        end
      end
      SZ_SHRINK: begin
        if (!at_min) begin
          size_d  = size_q - 1'b1;
          size_en = 1'b1;
        end
      end
      default: begin
        size_d  = size_q;
        size_en = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q <= SZ_W'(INIT_SZ);
    end else if (size_en) begin
      size_q <= size_d;
    end
  end

  assign size = size_q;

endmodule

// File: rtl/adaptive_slip_queue.sv
module adaptive_slip_queue
  import scq_pkg::*;
#(
  parameter int MAX_SLIP  = 16,
  parameter int MIN_SLIP  = 1,
  parameter int INIT_SLIP = 4,
  parameter int EVAL_WIN  = 32,
  localparam int SZ_W     = $clog2(MAX_SLIP + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            put_valid,
  output logic            put_ready,
  input  logic            get_valid,
  output logic            get_ready,
  input  logic            pf_done_valid,
  input  logic            pf_done_late,
  input  logic            pf_buf_full,
  output logic [SZ_W-1:0] slip_size,
  output logic [SZ_W-1:0] token_count
);

  size_act_e       resize_act;
  logic [SZ_W-1:0] cur_limit;

  scq_timeliness_mon #(
    .EVAL_WIN (EVAL_WIN)
  ) u_mon (
    .clk       (clk),
    .rst_n     (rst_n),
    .cls_valid (pf_done_valid),
    .cls_late  (pf_done_late),
    .buf_full  (pf_buf_full),
    .act       (resize_act)
  );

  scq_depth_ctl #(
    .SZ_W    (SZ_W),
    .MIN_SZ  (MIN_SLIP),
    .MAX_SZ  (MAX_SLIP),
    .INIT_SZ (INIT_SLIP)
  ) u_depth (
    .clk   (clk),
    .rst_n (rst_n),
    .act   (resize_act),
    .size  (cur_limit)
  );

  scq_token_ctr #(
    .CNT_W (SZ_W)
  ) u_tokens (
    .clk     (clk),
    .rst_n   (rst_n),
    .put_req (put_valid),
    .get_req (get_valid),
    .limit   (cur_limit),
    .put_ok  (put_ready),
    .get_ok  (get_ready),
    .count   (token_count)
  );

  assign slip_size = cur_limit;

endmodule

// File: rtl/scq_checker.sv
module scq_checker #(
  parameter int MAX_SLIP = 16,
  parameter int MIN_SLIP = 1,
  parameter int EVAL_WIN = 32,
  parameter int SZ_W     = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            put_valid,
  input logic            put_ready,
  input logic            get_valid,
  input logic            get_ready,
  input logic            pf_done_valid,
  input logic            pf_buf_full,
  input logic [SZ_W-1:0] slip_size,
  input logic [SZ_W-1:0] token_count
);

  localparam int CW_W = $clog2(EVAL_WIN + 1);

  logic [CW_W-1:0] seen_q;
  logic            seen_last;
  logic            put_acc, get_acc;

  assign seen_last = (seen_q == CW_W'(EVAL_WIN - 1));
  assign put_acc   = put_valid & put_ready;
  assign get_acc   = get_valid & get_ready;

  // independent classification counter for the window boundary
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= '0;
    end else if (pf_done_valid) begin
      seen_q <= seen_last ? '0 : seen_q + 1'b1;
    end
  end

  // R2
  put_incr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (put_acc && !get_acc) |=> (token_count == $past(token_count) + 1'b1));

  // R4
  get_decr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (get_acc && !put_acc) |=> (token_count == $past(token_count) - 1'b1));

  // R5
  both_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (put_acc && get_acc) |=> $stable(token_count));

  // R3
  refused_put_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (put_valid && !put_ready && !get_valid) |=> $stable(token_count));

  // R10
  size_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slip_size >= SZ_W'(MIN_SLIP)) && (slip_size <= SZ_W'(MAX_SLIP)));

  // R10
  size_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((slip_size == $past(slip_size)) ||
              (slip_size == $past(slip_size) + 1'b1) ||
              (slip_size + 1'b1 == $past(slip_size))));

  // R6
  size_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pf_done_valid && seen_last) |=> $stable(slip_size));

  // R9
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pf_buf_full |=> $stable(slip_size));

  // R11
  count_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    token_count <= SZ_W'(MAX_SLIP));

endmodule

bind adaptive_slip_queue scq_checker #(
  .MAX_SLIP (MAX_SLIP),
  .MIN_SLIP (MIN_SLIP),
  .EVAL_WIN (EVAL_WIN),
  .SZ_W     (SZ_W)
) u_scq_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .put_valid     (put_valid),
  .put_ready     (put_ready),
  .get_valid     (get_valid),
  .get_ready     (get_ready),
  .pf_done_valid (pf_done_valid),
  .pf_buf_full   (pf_buf_full),
  .slip_size     (slip_size),
  .token_count   (token_count)
);

// File: tb/tb_adaptive_slip_queue.sv
module tb_adaptive_slip_queue;

  localparam int CLK_PERIOD = 10;
  localparam int MAX_SLIP   = 16;
  localparam int MIN_SLIP   = 1;
  localparam int INIT_SLIP  = 4;
  localparam int EVAL_WIN   = 32;
  localparam int SZ_W       = $clog2(MAX_SLIP + 1);

  logic clk;
  logic rst_n;
  logic put_valid, get_valid, pf_done_valid, pf_done_late, pf_buf_full;
  logic put_ready, get_ready;
  logic [SZ_W-1:0] slip_size, token_count;

  int checks;
  int failures;
  bit done_flag;

  // model state
  int m_cnt, m_sz, m_late, m_useful, m_win;

  // scoreboard queues
  int    q_cnt[$];
  int    q_sz[$];
  bit    q_pr[$];
  bit    q_gr[$];
  string q_tag[$];

  adaptive_slip_queue #(
    .MAX_SLIP  (MAX_SLIP),
    .MIN_SLIP  (MIN_SLIP),
    .INIT_SLIP (INIT_SLIP),
    .EVAL_WIN  (EVAL_WIN)
  ) dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .put_valid     (put_valid),
    .put_ready     (put_ready),
    .get_valid     (get_valid),
    .get_ready     (get_ready),
    .pf_done_valid (pf_done_valid),
    .pf_done_late  (pf_done_late),
    .pf_buf_full   (pf_buf_full),
    .slip_size     (slip_size),
    .token_count   (token_count)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic push_exp(string tag);
    q_cnt.push_back(m_cnt);
    q_sz.push_back(m_sz);
    q_pr.push_back(m_cnt < m_sz);
    q_gr.push_back(m_cnt != 0);
    q_tag.push_back(tag);
  endtask

  // driver: one cycle of stimulus, model update, expected item pushed
  task automatic step(bit pv, bit gv, bit dv, bit late, bit full, string tag);
    bit pa, ga;
    @(negedge clk);
    put_valid     = pv;
    get_valid     = gv;
    pf_done_valid = dv;
    pf_done_late  = late;
    pf_buf_full   = full;
    pa = pv && (m_cnt < m_sz);
    ga = gv && (m_cnt > 0);
    if (pa && !ga) m_cnt++;
    if (ga && !pa) m_cnt--;
    if (dv) begin
      if (late) m_late++; else m_useful++;
      m_win++;
      if (m_win == EVAL_WIN) begin
        if (!full) begin
          if (2 * m_late > m_useful) begin
            if (m_sz < MAX_SLIP) m_sz++;
          end else begin
            if (m_sz > MIN_SLIP) m_sz--;
          end
        end
        m_win = 0; m_late = 0; m_useful = 0;
      end
    end
    @(posedge clk);
    #1;
    push_exp(tag);
  endtask

  task automatic run_window(int n_late, int n_useful, bit full_last, bit full_rest, string tag);
    int total;
    total = n_late + n_useful;
    for (int i = 0; i < total; i++) begin
      step(1'b0, 1'b0, 1'b1, (i < n_late), (i == total - 1) ? full_last : full_rest, tag);
    end
  endtask

  // monitor: pops expected items and compares against outputs
  initial begin
    forever begin
      wait (q_cnt.size() > 0);
      checks++;
      if (int'(token_count) != q_cnt[0] || int'(slip_size) != q_sz[0] ||
          put_ready != q_pr[0] || get_ready != q_gr[0]) begin
        failures++;
        $display("FAIL %s: actual cnt=%0d sz=%0d pr=%0b gr=%0b expected cnt=%0d sz=%0d pr=%0b gr=%0b",
                 q_tag[0], token_count, slip_size, put_ready, get_ready,
                 q_cnt[0], q_sz[0], q_pr[0], q_gr[0]);
      end
      void'(q_cnt.pop_front());
      void'(q_sz.pop_front());
      void'(q_pr.pop_front());
      void'(q_gr.pop_front());
      void'(q_tag.pop_front());
    end
  end

  // watchdog
  initial begin
    #(CLK_PERIOD * 200000);
    if (!done_flag) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    checks = 0; failures = 0; done_flag = 0;
    put_valid = 0; get_valid = 0; pf_done_valid = 0; pf_done_late = 0; pf_buf_full = 0;
    m_cnt = 0; m_sz = INIT_SLIP; m_late = 0; m_useful = 0; m_win = 0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    push_exp("R1 in reset");
    @(negedge clk);
    rst_n = 1'b1;
    step(0, 0, 0, 0, 0, "R1 after release");

    // R2, R3: fill past the limit
    for (int i = 0; i < 6; i++) step(1, 0, 0, 0, 0, "R2/R3 fill");
    // R4: drain past empty
    for (int i = 0; i < 5; i++) step(0, 1, 0, 0, 0, "R4 drain");
    // R5: simultaneous accepted put and get
    step(1, 0, 0, 0, 0, "R2 put");
    step(1, 0, 0, 0, 0, "R2 put");
    step(1, 1, 0, 0, 0, "R5 both");
    step(1, 1, 0, 0, 0, "R5 both");

    // R6: 31 late classifications with idle gaps, size must stay
    for (int i = 0; i < EVAL_WIN - 1; i++) begin
      step(0, 0, 1, 1, 0, "R6 partial window");
      step(0, 0, 0, 1, 0, "R6 idle cycle");
    end
    step(0, 0, 1, 1, 0, "R7 window end all late");  // size 4 -> 5

    // R11: fill to 5 then shrink below the count
    for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, "R2 fill to 5");
    run_window(0, EVAL_WIN, 0, 0, "R8 all useful");   // 5 -> 4, count 5
    step(1, 0, 0, 0, 0, "R11 put blocked over size");
    step(0, 1, 0, 0, 0, "R11 get to 4, still blocked");
    step(1, 0, 0, 0, 0, "R11 put blocked at size");
    step(0, 1, 0, 0, 0, "R11 get to 3");
    step(1, 0, 0, 0, 0, "R11 put accepted again");
    step(0, 1, 0, 0, 0, "R4 get");

    // R7 / R8 threshold split
    run_window(11, 21, 0, 0, "R7 11 late 21 useful");  // 4 -> 5
    run_window(10, 22, 0, 0, "R8 10 late 22 useful");  // 5 -> 4
    // R6: tallies cleared: late window then all-useful must shrink
    run_window(EVAL_WIN, 0, 0, 0, "R6 late window");   // 4 -> 5
    run_window(0, EVAL_WIN, 0, 0, "R6 cleared tallies"); // 5 -> 4

    // R9: full at review holds; full elsewhere ignored
    run_window(EVAL_WIN, 0, 1, 0, "R9 full at review");  // hold 4
    run_window(EVAL_WIN, 0, 0, 1, "R9 full before review"); // 4 -> 5

    // R10: clamp at the top
    for (int w = 0; w < 12; w++) run_window(EVAL_WIN, 0, 0, 0, "R10 grow to max");
    run_window(EVAL_WIN, 0, 0, 0, "R10 grow at max");
    // R10: clamp at the bottom
    for (int w = 0; w < 16; w++) run_window(0, EVAL_WIN, 0, 0, "R10 shrink to min");
    run_window(0, EVAL_WIN, 0, 0, "R10 shrink at min");

    // drain and confirm limit of one
    for (int i = 0; i < 4; i++) step(0, 1, 0, 0, 0, "R4 drain at min");
    step(1, 0, 0, 0, 0, "R2 put at min");
    step(1, 0, 0, 0, 0, "R3 put refused at min");

    wait (q_cnt.size() == 0);
    #1;
    done_flag = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule